// File: doc/BRIEF.md
# Soft-Start, Fault Shutdown and Timed Restart Sequencer

This block paces the start-up and fault recovery of a switching power stage. A digital accumulator acts as the soft reference: the regulation loop uses its value as the set-point. The accumulator climbs quickly during soft-start and falls slowly while a restart delay is being timed. Two latches decide when the power outputs must be held off. The first records a fault. The second records that the restart delay is running.

An undervoltage condition clears the reference and sets both latches. Once the reference sits at zero, the fault latch releases and the delay latch follows one cycle later. Soft-start charging then begins. A fault in normal running shuts the outputs at once and starts the slow discharge right away. A fault during soft-start also shuts the outputs at once, but charging continues up to the four-fifths threshold before the discharge starts. The outputs come back only after the reference has run down to zero with the fault input low.

The fault input is asynchronous and passes through a two-flop synchroniser. A permanent-latch option freezes the discharge, so a fault then stays latched until the next undervoltage event.

Top module: `softstart_restart_seq`

## Requirements
- R1: Reset, and any edge with `uv_i` high, leave fault latch = 1, delay latch = 1 and `softref_o` = 0 after that edge. `inhibit_o` is 1 whenever `uv_i` is 1, in the same cycle.
- R2: With the delay latch set, `softref_o` = 0 and the synchronised fault low, the fault latch clears on the next edge. The delay latch clears on the edge after that, with `softref_o` still 0.
- R3: While the delay latch is clear and no stop condition applies, `softref_o` rises by `chg_step_i` on every edge. It saturates at FS = 2^ACC_W - 1 without wrapping, so it reaches FS exactly ceil(FS / step) edges after the delay latch clears.
- R4: The fault input reaches the latch logic through two flops. A rise applied between edges sets the fault latch on the third edge that follows.
- R5: When the fault latch sets while `softref_o` >= THR, with THR = floor(FS * 4 / 5), the delay latch sets on the same edge.
- R6: While the delay latch is set and the permanent-latch option is off, `softref_o` falls by `dis_step_i` once every DIS_DIV edges, saturating at 0. The first decrement comes DIS_DIV edges after the edge that set the delay latch. From FS with equal steps, this makes the discharge DIS_DIV times longer than soft-start.
- R7: At `softref_o` = 0 the fault latch stays set for as long as the synchronised fault is high. It clears on the first edge at which the synchronised fault is low.
- R8: When the fault latch is set while `softref_o` < THR, charging continues. It stops at the first value >= THR, which is ceil(THR / step) * step. The delay latch sets on the next edge, and the R6 discharge follows.
- R9: With `hold_latched_i` = 1 and the delay latch set, `softref_o` does not change, so the fault stays latched until an undervoltage event clears the reference.
- R10: `inhibit_o` = fault latch OR `uv_i` OR NOT `supply_ok_i`. `soft_start_o` = 1 exactly when both latches are clear and `softref_o` is below FS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_i | input | 1 | Supply undervoltage flag |
| supply_ok_i | input | 1 | Internal bias supply ready |
| fault_async_i | input | 1 | Fault request, asynchronous |
| chg_step_i | input | STEP_W | Soft-start increment per cycle |
| dis_step_i | input | STEP_W | Restart-delay decrement per DIS_DIV cycles |
| hold_latched_i | input | 1 | Permanent-latch option: freeze the discharge |
| softref_o | output | ACC_W | Soft reference value |
| inhibit_o | output | 1 | Power outputs must be held off |
| fault_latched_o | output | 1 | Fault latch state |
| delay_latched_o | output | 1 | Delay latch state |
| soft_start_o | output | 1 | Soft-start ramp in progress |

## Verification
The bench sweeps the charge step from 1 to 16 and several discharge steps, including one equal to full scale. An accumulator that wrapped, or that got its step pacing wrong, would miss the exact ramp and delay cycle counts computed in the bench. A separate fault during soft-start checks that charging stops at the first value past the four-fifths threshold. A design that set the delay latch too early, or let the ramp run on, would show the wrong peak. A fault held high at zero, and the permanent-latch option, check that the latch never releases early. A release that ignored the fault level, or a discharge that leaked, would show up as an early clear.

// File: rtl/ssr_pkg.sv
// Shared types for the soft-start / restart sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ssr_pkg;
    // Operation applied to the soft reference accumulator on an edge
    typedef enum logic [1:0] {
        ACC_HOLD      = 2'd0,
        ACC_CHARGE    = 2'd1,
        ACC_DISCHARGE = 2'd2,
        ACC_CLEAR     = 2'd3
    } acc_op_e;
endpackage

// File: rtl/ssr_fault_sync.sv
// Multi-flop synchroniser for the asynchronous fault request.
// Assumes: STAGES >= 2; reset drives every stage to the idle (low) level.
module ssr_fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw request through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ssr_softref_acc.sv
// Soft reference accumulator: saturating charge by one step per edge,
// paced saturating discharge by one step every DIS_DIV edges, and clear.
// Assumes: STEP_W <= ACC_W, DIS_DIV >= 2.
module ssr_softref_acc
    import ssr_pkg::*;
#(
    parameter int ACC_W   = 12,
    parameter int STEP_W  = 8,
    parameter int DIS_DIV = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_op_e           op_i,
    input  logic [STEP_W-1:0] chg_step_i,
    input  logic [STEP_W-1:0] dis_step_i,
    output logic [ACC_W-1:0]  ref_o
);
    localparam int CNT_W = $clog2(DIS_DIV);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIS_DIV - 1);
    localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

    logic [ACC_W-1:0] ref_q;
    logic [CNT_W-1:0] pace_q;
    logic [ACC_W:0]   sum_w;
    logic [ACC_W-1:0] up_w;
    logic [ACC_W-1:0] down_w;
    logic [ACC_W:0]   chg_ext;
    logic [ACC_W:0]   dis_ext;

    // Widen steps and form the saturated next values
    always_comb begin
        chg_ext = (ACC_W+1)'(chg_step_i);
        dis_ext = (ACC_W+1)'(dis_step_i);
        sum_w   = {1'b0, ref_q} + chg_ext;
        up_w    = sum_w[ACC_W] ? FULL : sum_w[ACC_W-1:0];
        down_w  = ({1'b0, ref_q} < dis_ext) ? '0 : (ref_q - dis_ext[ACC_W-1:0]);
    end

    // Update the reference and the discharge pacing counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            pace_q <= '0;
        end else begin
            case (op_i)
                ACC_CLEAR: begin
                    ref_q  <= '0;
                    pace_q <= '0;
                end
                ACC_CHARGE: begin
                    ref_q  <= up_w;
                    pace_q <= '0;
                end
                ACC_DISCHARGE: begin
                    if (pace_q == CNT_LAST) begin
                        ref_q  <= down_w;
                        pace_q <= '0;
                    end else begin
                        pace_q <= pace_q + 1'b1;
                    end
                end
                default: pace_q <= '0;
            endcase
        end
    end

    assign ref_o = ref_q;

    // R3: charging never wraps below the previous value
    assert_charge_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == ACC_CHARGE |=> ref_q >= $past(ref_q));
    // R6: discharging never wraps above the previous value
    assert_discharge_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == ACC_DISCHARGE |=> ref_q <= $past(ref_q));
    // R1: a clear leaves the reference at zero
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == ACC_CLEAR |=> ref_q == '0);
endmodule

// File: rtl/ssr_latch_ctl.sv
// Fault latch and delay latch. The fault latch sets on a synchronised fault
// or undervoltage and releases at zero reference once the delay latch is set
// and the fault is low. The delay latch sets above threshold while a fault is
// present and releases once the fault latch is clear.
// Assumes: at_zero_i and above_thr_i come from the registered reference.
module ssr_latch_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_i,
    input  logic fault_sync_i,
    input  logic at_zero_i,
    input  logic above_thr_i,
    output logic fault_q_o,
    output logic delay_q_o
);
    logic fault_q;
    logic delay_q;
    logic fault_d;
    logic delay_d;

    // Next state of the fault latch: set has priority over release
    always_comb begin
        if (uv_i)                              fault_d = 1'b1;
        else if (fault_sync_i)                 fault_d = 1'b1;
        else if (fault_q && delay_q && at_zero_i) fault_d = 1'b0;
        else                                   fault_d = fault_q;
    end

    // Next state of the delay latch
    always_comb begin
        if (uv_i)                                    delay_d = 1'b1;
        else if ((fault_q || fault_sync_i) && above_thr_i) delay_d = 1'b1;
        else if (!fault_q)                           delay_d = 1'b0;
        else                                         delay_d = delay_q;
    end

    // Latch registers; reset behaves as an undervoltage event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b1;
            delay_q <= 1'b1;
        end else begin
            fault_q <= fault_d;
            delay_q <= delay_d;
        end
    end

    assign fault_q_o = fault_q;
    assign delay_q_o = delay_q;

    // R1: undervoltage sets both latches
    assert_uv_sets_latches_R1: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> fault_q && delay_q);
    // R4: a synchronised fault always sets the fault latch
    assert_fault_sets_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sync_i |=> fault_q);
    // R5: fault with reference above threshold sets the delay latch at once
    assert_delay_above_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sync_i && above_thr_i |=> delay_q);
    // R7: the fault latch only releases at zero with the fault low
    assert_release_needs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(at_zero_i) && !$past(fault_sync_i) && !$past(uv_i));
    // R2: the delay latch only releases after the fault latch has released
    assert_delay_after_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(delay_q) |-> !$past(fault_q));
endmodule

// File: rtl/softstart_restart_seq.sv
// Top: sequences soft-start, fault shutdown and timed restart around a
// digital soft reference. Chooses the accumulator operation from the latch
// states and drives the output inhibit and state flags.
// Assumes: STEP_W <= ACC_W, DIS_DIV >= 2, SYNC_STAGES >= 2.
module softstart_restart_seq
    import ssr_pkg::*;
#(
    parameter int ACC_W       = 12,
    parameter int STEP_W      = 8,
    parameter int DIS_DIV     = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_i,
    input  logic              supply_ok_i,
    input  logic              fault_async_i,
    input  logic [STEP_W-1:0] chg_step_i,
    input  logic [STEP_W-1:0] dis_step_i,
    input  logic              hold_latched_i,
    output logic [ACC_W-1:0]  softref_o,
    output logic              inhibit_o,
    output logic              fault_latched_o,
    output logic              delay_latched_o,
    output logic              soft_start_o
);
    localparam longint FS_VAL  = (64'd1 << ACC_W) - 1;
    localparam longint THR_VAL = (FS_VAL * 4) / 5;
    localparam logic [ACC_W-1:0] FULL = ACC_W'(FS_VAL);
    localparam logic [ACC_W-1:0] THR  = ACC_W'(THR_VAL);

    logic             fault_sync;
    logic             fault_q;
    logic             delay_q;
    logic [ACC_W-1:0] ref_w;
    logic             at_zero;
    logic             above_thr;
    acc_op_e          op;

    ssr_fault_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fault_async_i),
        .sync_o  (fault_sync)
    );

    ssr_latch_ctl latch_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_i         (uv_i),
        .fault_sync_i (fault_sync),
        .at_zero_i    (at_zero),
        .above_thr_i  (above_thr),
        .fault_q_o    (fault_q),
        .delay_q_o    (delay_q)
    );

    ssr_softref_acc #(.ACC_W(ACC_W), .STEP_W(STEP_W), .DIS_DIV(DIS_DIV)) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .chg_step_i (chg_step_i),
        .dis_step_i (dis_step_i),
        .ref_o      (ref_w)
    );

    // Reference level detectors
    always_comb begin
        at_zero   = (ref_w == '0);
        above_thr = (ref_w >= THR);
    end

    // Pick the accumulator operation: clear > discharge > stop > charge
    always_comb begin
        if (uv_i)                         op = ACC_CLEAR;
        else if (delay_q)                 op = hold_latched_i ? ACC_HOLD : ACC_DISCHARGE;
        else if (fault_q && above_thr)    op = ACC_HOLD;
        else                              op = ACC_CHARGE;
    end

    // Output flags
    always_comb begin
        softref_o       = ref_w;
        inhibit_o       = fault_q | uv_i | ~supply_ok_i;
        fault_latched_o = fault_q;
        delay_latched_o = delay_q;
        soft_start_o    = ~fault_q & ~delay_q & (ref_w != FULL);
    end

    // R9: the permanent-latch option freezes the reference during the delay
    assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_latched_i && delay_q && !uv_i |=> $stable(ref_w));
    // R8: with the fault latched, charging never goes past the first value above threshold
    assert_no_charge_past_thr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q && above_thr && !uv_i |=> ref_w <= $past(ref_w));
    // R10: a latched fault always inhibits the outputs
    assert_fault_inhibits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> inhibit_o);
endmodule

// File: tb/softstart_restart_seq_tb.sv
// Self-checking bench: sweeps step sizes and checks ramp and delay cycle counts.
module softstart_restart_seq_tb_top;
    localparam int ACC_W   = 8;
    localparam int STEP_W  = 8;
    localparam int DIS_DIV = 25;
    localparam int FS      = (1 << ACC_W) - 1;
    localparam int THR     = (FS * 4) / 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv = 1'b1;
    logic sup_ok = 1'b1;
    logic flt = 1'b0;
    logic [STEP_W-1:0] chg = 8'd5;
    logic [STEP_W-1:0] dis = 8'd5;
    logic hold = 1'b0;
    logic [ACC_W-1:0] sref;
    logic inh, fl, dl, ss;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    softstart_restart_seq #(.ACC_W(ACC_W), .STEP_W(STEP_W), .DIS_DIV(DIS_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .uv_i(uv), .supply_ok_i(sup_ok),
        .fault_async_i(flt), .chg_step_i(chg), .dis_step_i(dis),
        .hold_latched_i(hold), .softref_o(sref), .inhibit_o(inh),
        .fault_latched_o(fl), .delay_latched_o(dl), .soft_start_o(ss)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Undervoltage pulse, release, and a checked soft-start ramp to full scale
    task automatic power_up(input int step);
        int n;
        int prev;
        int expv;
        bit ok;
        bit flag_ok;
        chg = STEP_W'(step);
        @(negedge clk); uv = 1'b1;
        #1 chk(inh == 1'b1, "R1", "inhibit during uv", inh, 1);
        @(negedge clk);
        chk(sref == 0 && fl && dl, "R1", "uv clears ref, sets latches", sref, 0);
        uv = 1'b0;
        @(negedge clk);
        chk(fl == 1'b0 && dl == 1'b1, "R2", "fault releases first", {fl, dl}, 1);
        @(negedge clk);
        chk(dl == 1'b0 && sref == 0, "R2", "delay releases next, ref 0", {dl, sref}, 0);
        n = 0; prev = 0; ok = 1'b1; flag_ok = 1'b1;
        while (sref != FS && n < 1000) begin
            if (!ss) flag_ok = 1'b0;
            @(negedge clk);
            n++;
            expv = (prev + step > FS) ? FS : prev + step;
            if (sref != expv) ok = 1'b0;
            prev = sref;
        end
        chk(n == ceil_div(FS, step), "R3", "ramp length", n, ceil_div(FS, step));
        chk(ok, "R3", "ramp step/saturation", sref, FS);
        chk(flag_ok && ss == 1'b0, "R10", "soft_start flag", ss, 0);
    endtask

    // Fault from full scale, held through the discharge, then released
    task automatic normal_fault(input int dstep);
        int n;
        int prev;
        bit ok;
        dis = STEP_W'(dstep);
        @(negedge clk); flt = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(fl == 1'b0, "R4", "no latch after two edges", fl, 0);
        @(negedge clk);
        chk(fl == 1'b1, "R4", "latch on third edge", fl, 1);
        chk(dl == 1'b1, "R5", "delay set with fault above thr", dl, 1);
        chk(inh == 1'b1, "R10", "inhibit with fault", inh, 1);
        n = 0; prev = sref; ok = 1'b1;
        while (sref != 0 && n < 20000) begin
            @(negedge clk);
            n++;
            if (sref != prev) begin
                if (n % DIS_DIV != 0) ok = 1'b0;
                if (sref != ((prev > dstep) ? prev - dstep : 0)) ok = 1'b0;
            end
            prev = sref;
        end
        chk(n == ceil_div(FS, dstep) * DIS_DIV, "R6", "discharge length", n,
            ceil_div(FS, dstep) * DIS_DIV);
        chk(ok, "R6", "discharge pacing/saturation", sref, 0);
        repeat (40) @(negedge clk);
        chk(fl == 1'b1 && sref == 0, "R7", "latch held while fault high", fl, 1);
        flt = 1'b0;
        n = 0;
        while (fl && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3, "R7", "release edges after fault low", n, 3);
        @(negedge clk);
        chk(dl == 1'b0, "R2", "delay released after fault", dl, 0);
    endtask

    // Fault during soft-start: charge to threshold, then discharge
    task automatic softstart_fault(input int step, input int dstep);
        int n;
        int peak;
        chg = STEP_W'(step);
        dis = STEP_W'(dstep);
        peak = ceil_div(THR, step) * step;
        @(negedge clk); uv = 1'b1;
        @(negedge clk); uv = 1'b0;
        n = 0;
        while ((dl || sref < 50) && n < 1000) begin @(negedge clk); n++; end
        flt = 1'b1;
        repeat (4) @(negedge clk);
        flt = 1'b0;
        chk(fl == 1'b1 && dl == 1'b0, "R8", "latched, delay clear below thr", dl, 0);
        n = 0;
        while (!dl && n < 1000) begin @(negedge clk); n++; end
        chk(sref == peak, "R8", "peak at first value above thr", sref, peak);
        n = 0;
        while (sref != 0 && n < 20000) begin @(negedge clk); n++; end
        chk(n == ceil_div(peak, dstep) * DIS_DIV, "R8", "discharge from peak", n,
            ceil_div(peak, dstep) * DIS_DIV);
        @(negedge clk);
        chk(fl == 1'b0, "R7", "release at zero with fault low", fl, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(fl && dl && sref == 0 && inh, "R1", "reset state", {fl, dl, sref}, 0);
        rst_n = 1'b1;
        for (int s = 1; s <= 16; s++) power_up(s);
        power_up(5); normal_fault(5);
        power_up(5); normal_fault(3);
        power_up(7); normal_fault(16);
        power_up(9); normal_fault(255);
        softstart_fault(5, 7);
        softstart_fault(3, 1);
        // R9: permanent-latch option keeps the fault latched
        power_up(5);
        hold = 1'b1;
        @(negedge clk); flt = 1'b1;
        repeat (4) @(negedge clk);
        flt = 1'b0;
        repeat (2000) @(negedge clk);
        chk(sref == FS && fl && dl, "R9", "ref frozen, fault kept", sref, FS);
        power_up(5);
        chk(fl == 1'b0 && sref == FS, "R9", "recovery after uv with option on", fl, 0);
        hold = 1'b0;
        // R10: supply not ready inhibits without a fault
        @(negedge clk); sup_ok = 1'b0;
        #1 chk(inh == 1'b1 && fl == 1'b0, "R10", "inhibit when supply not ready", inh, 1);
        @(negedge clk); sup_ok = 1'b1;
        #1 chk(inh == 1'b0, "R10", "no inhibit when running", inh, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule